// File: doc/BRIEF.md
# Compare Channel with Square-Wave Output

This block is one compare channel that watches a free-running 16-bit timebase. It has two ways to toggle its output pin. In high-speed mode the pin inverts whenever the whole 16-bit counter value equals the channel's 16-bit compare word. In square-wave mode only the low byte of the counter is compared. On each such match the pin inverts, and the low compare byte moves forward by an offset held in the high compare byte. The pin therefore toggles every `offset` timebase ticks, which gives a square wave at timebase rate / (2 × offset).

The timebase is outside the block. It supplies the counter value and a strobe that marks the cycles on which the counter advances. A match counts only on those cycles. Software loads a mode byte and the two compare bytes through simple write strobes. Writing the low byte disarms the comparator and writing the high byte arms it again, so a two-byte update never meets a half-written compare word. A sticky match flag records full 16-bit matches when flag reporting is enabled, and it serves as the interrupt request.

Top module: `cmp_freq_channel`

## Requirements
- R1: After reset the pin is low, the match flag is clear, and the comparator is disarmed, so a running counter causes no toggle.
- R2: The mode write takes `modeIn` bits as follows: bit 3 arms the comparator, bit 2 enables toggling, bit 1 selects square-wave mode, and bit 0 enables the match flag. Square-wave behaviour occurs only when bits 3, 2 and 1 are all set. With bit 2 clear the pin never toggles.
- R3: In square-wave mode only the counter's low byte is compared with the low compare byte. On a match the pin inverts and the low compare byte becomes (low + high) mod 256. Successive toggles are therefore exactly `offset` advancing ticks apart.
- R4: In square-wave mode an offset of 0 gives a half-period of 256 advancing ticks.
- R5: In high-speed mode (bits 3 and 2 set, bit 1 clear) the pin inverts only when all 16 counter bits equal the compare word. A match on the low byte alone has no effect.
- R6: A match is evaluated only on a cycle where `timerAdv` is high. A stalled counter sitting on the compare value produces no further toggles, and stalled cycles do not count toward the half-period.
- R7: Writing the low compare byte disarms the comparator and writing the high compare byte arms it.
- R8: While the comparator is disarmed the pin holds its current level.
- R9: When bit 0 is set, the flag is set by a full 16-bit match of counter and compare word on an advancing cycle, in either mode. In square-wave mode a match on the low byte alone does not set it.
- R10: The flag stays set until `flagClr` is pulsed. If a new match and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Current timebase counter value |
| timerAdv | input | 1 | High on cycles where the counter advances |
| modeWe | input | 1 | Write strobe for the mode bits |
| modeIn | input | 4 | Mode bits {arm, toggle, square-wave, flag enable} |
| lowWe | input | 1 | Write strobe for the low compare byte (disarms) |
| highWe | input | 1 | Write strobe for the high compare byte (arms) |
| wrByte | input | 8 | Data for compare-byte writes |
| flagClr | input | 1 | Clears the match flag |
| pinOut | output | 1 | Channel output pin level |
| matchFlag | output | 1 | Sticky match flag and interrupt request |

## Verification
Square-wave mode is run against a bench-side counter with offsets 1, 100, 255 and 0. The bench measures every gap between toggles in advancing ticks, which separates a correct offset add from an off-by-one error and from a failure to wrap 0 to 256. One run stalls the counter on every third cycle, which shows that stalled cycles are not counted. High-speed mode is driven with hand-picked counter values that match on the low byte only, on the full word, and on the full word while the counter is stalled. These separate a 16-bit compare from an 8-bit one and separate strobe-qualified matching from level matching. Flag tests place a low-byte-only match beside a full match, and they stage a clear in the same cycle as a set.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;
  localparam int MODE_W   = 4;
  localparam int BIT_FLAG = 0;
  localparam int BIT_SQW  = 1;
  localparam int BIT_TOG  = 2;
  localparam int BIT_ARM  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic stepLo;
    logic flipPin;
  } dpCtl_t;

  // compare results from datapath to control (already qualified by timerAdv)
  typedef struct packed {
    logic lowHit;
    logic fullHit;
  } dpHit_t;
endpackage

// File: rtl/cmpch_dp.sv
module cmpch_dp
  import cmpch_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TIMER_W-1:0]   timerVal,
  input  logic                 timerAdv,
  input  logic [TIMER_W/2-1:0] wrByte,
  input  dpCtl_t               ctl,
  output dpHit_t               hit,
  output logic                 pinOut
);
  localparam int HALF_W = TIMER_W / 2;

  logic [HALF_W-1:0] cmpLo;
  logic [HALF_W-1:0] cmpHi;
  logic              pinReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpLo  <= '0;
      cmpHi  <= '0;
      pinReg <= 1'b0;
    end else begin
      if (ctl.loadLo)      cmpLo <= wrByte;
      else if (ctl.stepLo) cmpLo <= cmpLo + cmpHi;  // offset 0 wraps to a full 256 step
      if (ctl.loadHi)      cmpHi <= wrByte;
      if (ctl.flipPin)     pinReg <= ~pinReg;
    end
  end

  always_comb begin
    hit.lowHit  = timerAdv && (timerVal[HALF_W-1:0] == cmpLo);
    hit.fullHit = timerAdv && (timerVal == {cmpHi, cmpLo});
  end

  assign pinOut = pinReg;

  AST_NO_ADV_NO_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    !timerAdv |=> $stable(pinOut)); // R6

  AST_FLIP_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (!hit.lowHit && !hit.fullHit) |=> $stable(pinOut)); // R3
endmodule

// File: rtl/cmpch_ctrl.sv
module cmpch_ctrl
  import cmpch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              lowWe,
  input  logic              highWe,
  input  logic              flagClr,
  input  dpHit_t            hit,
  output dpCtl_t            ctl,
  output logic              matchFlag
);
  logic armed;
  logic togEn;
  logic sqwSel;
  logic flagEn;
  logic flagReg;
  logic sqwMode;
  logic hsMode;
  logic flagSet;

  always_comb begin
    sqwMode = armed && togEn && sqwSel;
    hsMode  = armed && togEn && !sqwSel;
    flagSet = armed && flagEn && hit.fullHit;
    ctl.loadLo  = lowWe;
    ctl.loadHi  = highWe;
    ctl.stepLo  = sqwMode && hit.lowHit;
    ctl.flipPin = (sqwMode && hit.lowHit) || (hsMode && hit.fullHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      togEn   <= 1'b0;
      sqwSel  <= 1'b0;
      flagEn  <= 1'b0;
      flagReg <= 1'b0;
    end else begin
      if (modeWe) begin
        togEn  <= modeIn[BIT_TOG];
        sqwSel <= modeIn[BIT_SQW];
        flagEn <= modeIn[BIT_FLAG];
      end
      // arm priority: high-byte write, then low-byte write, then mode write
      if (highWe)      armed <= 1'b1;
      else if (lowWe)  armed <= 1'b0;
      else if (modeWe) armed <= modeIn[BIT_ARM];
      if (flagSet)      flagReg <= 1'b1;
      else if (flagClr) flagReg <= 1'b0;
    end
  end

  assign matchFlag = flagReg;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && !flagClr) |=> matchFlag); // R10

  AST_LOW_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (lowWe && !highWe) |=> !ctl.flipPin); // R7

  AST_HS_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && !hit.fullHit) |-> !ctl.flipPin); // R5

  AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !ctl.flipPin); // R8

  AST_FLAG_FULL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!matchFlag && !hit.fullHit) |=> !matchFlag); // R9
endmodule

// File: rtl/cmp_freq_channel.sv
module cmp_freq_channel
  import cmpch_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TIMER_W-1:0]   timerVal,
  input  logic                 timerAdv,
  input  logic                 modeWe,
  input  logic [MODE_W-1:0]    modeIn,
  input  logic                 lowWe,
  input  logic                 highWe,
  input  logic [TIMER_W/2-1:0] wrByte,
  input  logic                 flagClr,
  output logic                 pinOut,
  output logic                 matchFlag
);
  dpCtl_t ctl;
  dpHit_t hit;

  cmpch_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeWe    (modeWe),
    .modeIn    (modeIn),
    .lowWe     (lowWe),
    .highWe    (highWe),
    .flagClr   (flagClr),
    .hit       (hit),
    .ctl       (ctl),
    .matchFlag (matchFlag)
  );

  cmpch_dp #(.TIMER_W(TIMER_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .timerVal (timerVal),
    .timerAdv (timerAdv),
    .wrByte   (wrByte),
    .ctl      (ctl),
    .hit      (hit),
    .pinOut   (pinOut)
  );
endmodule

// File: tb/test_cmp_freq_channel.sv
module test_cmp_freq_channel;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] timerVal;
  logic        timerAdv;
  logic        modeWe;
  logic [3:0]  modeIn;
  logic        lowWe;
  logic        highWe;
  logic [7:0]  wrByte;
  logic        flagClr;
  logic        pinOut;
  logic        matchFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_freq_channel i_cmp_freq_channel (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .timerAdv(timerAdv),
    .modeWe(modeWe), .modeIn(modeIn), .lowWe(lowWe), .highWe(highWe),
    .wrByte(wrByte), .flagClr(flagClr), .pinOut(pinOut), .matchFlag(matchFlag)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrMode(logic [3:0] m);
    modeIn = m; modeWe = 1'b1; cyc(); modeWe = 1'b0;
  endtask

  task automatic wrLo(logic [7:0] b);
    wrByte = b; lowWe = 1'b1; cyc(); lowWe = 1'b0;
  endtask

  task automatic wrHi(logic [7:0] b);
    wrByte = b; highWe = 1'b1; cyc(); highWe = 1'b0;
  endtask

  task automatic drive(logic [15:0] v, logic a);
    timerVal = v; timerAdv = a; cyc(); timerAdv = 1'b0;
  endtask

  // free-run the counter for n cycles and return the number of pin toggles
  task automatic freeRun(int n, output int toggles);
    logic p;
    logic [15:0] tv;
    tv = 16'h0;
    toggles = 0;
    p = pinOut;
    for (int i = 0; i < n; i++) begin
      timerVal = tv; timerAdv = 1'b1; cyc(); tv++;
      if (pinOut != p) begin toggles++; p = pinOut; end
    end
    timerAdv = 1'b0;
  endtask

  // square-wave run: measure gaps between toggles in advancing ticks
  task automatic runFreq(int h, int lo, int stallEvery, int halves, string req);
    int expH, ticks, got, guard;
    bit seen, a;
    logic p;
    logic [15:0] tv;
    wrMode(4'b1110);
    wrLo(lo[7:0]);
    wrHi(h[7:0]);
    expH = (h == 0) ? 256 : h;
    tv = 16'h0; ticks = 0; got = 0; guard = 0; seen = 0;
    p = pinOut;
    while (got < halves && guard < 5000) begin
      guard++;
      a = (stallEvery == 0) || (guard % stallEvery != 0);
      timerVal = tv; timerAdv = a; cyc();
      if (a) begin tv++; ticks++; end
      if (pinOut != p) begin
        p = pinOut;
        if (seen) begin
          chk(ticks == expH, req, ticks, expH);
          got++;
        end
        seen = 1;
        ticks = 0;
      end
    end
    timerAdv = 1'b0;
    chk(got == halves, req, got, halves);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tg;
    logic p;
    rstN = 1'b0; timerVal = '0; timerAdv = 1'b0; modeWe = 1'b0; modeIn = '0;
    lowWe = 1'b0; highWe = 1'b0; wrByte = '0; flagClr = 1'b0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1 reset state
    chk(pinOut == 1'b0, "R1 pin", pinOut, 0);
    chk(matchFlag == 1'b0, "R1 flag", matchFlag, 0);
    freeRun(300, tg);
    chk(tg == 0, "R1 disarmed after reset", tg, 0);

    // R3 / R4 / R6 square-wave periods
    runFreq(1,   5,    0, 6, "R3 offset1");
    runFreq(100, 8'h40, 0, 4, "R3 offset100");
    runFreq(255, 3,    0, 3, "R3 offset255");
    runFreq(100, 7,    3, 4, "R6 stalled offset100");
    runFreq(0,   9,    0, 3, "R4 offset0");

    // R7 / R8: low write disarms, high write rearms
    wrLo(8'h11);
    p = pinOut;
    freeRun(600, tg);
    chk(tg == 0, "R7 low write disarms", tg, 0);
    chk(pinOut == p, "R8 pin holds", pinOut, p);
    wrHi(8'd50);
    freeRun(300, tg);
    chk(tg > 0, "R7 high write arms", tg, 1);

    // R2: square-wave select without toggle enable
    wrMode(4'b1010); wrLo(8'h03); wrHi(8'h04);
    freeRun(600, tg);
    chk(tg == 0, "R2 no toggle without bit2", tg, 0);
    // R2 / R8: toggle+square but mode write disarms
    wrLo(8'h03); wrHi(8'h04); wrMode(4'b0110);
    freeRun(600, tg);
    chk(tg == 0, "R2 R8 disarmed by mode", tg, 0);

    // R5 high-speed full compare
    wrMode(4'b1100); wrLo(8'h34); wrHi(8'h12);
    p = pinOut;
    drive(16'h1134, 1'b1);
    chk(pinOut == p, "R5 low-only match ignored", pinOut, p);
    drive(16'h0034, 1'b1);
    chk(pinOut == p, "R5 low-only match ignored 2", pinOut, p);
    // R6 stall on compare value
    for (int i = 0; i < 5; i++) drive(16'h1234, 1'b0);
    chk(pinOut == p, "R6 no match without advance", pinOut, p);
    drive(16'h1234, 1'b1);
    chk(pinOut == !p, "R5 full match toggles", pinOut, !p);
    for (int i = 0; i < 8; i++) drive(16'h1234, 1'b0);
    chk(pinOut == !p, "R6 single toggle on stall", pinOut, !p);

    // R9 / R10 flag in square-wave mode
    wrMode(4'b1111); wrLo(8'h10); wrHi(8'h20);
    p = pinOut;
    drive(16'h0010, 1'b1);
    chk(pinOut == !p, "R3 low match toggles", pinOut, !p);
    chk(matchFlag == 1'b0, "R9 low-only no flag", matchFlag, 0);
    drive(16'h2010, 1'b1);
    chk(pinOut == !p, "R3 low byte stepped", pinOut, !p);
    chk(matchFlag == 1'b0, "R9 stale word no flag", matchFlag, 0);
    drive(16'h2030, 1'b1);
    chk(matchFlag == 1'b1, "R9 full match sets flag", matchFlag, 1);
    chk(pinOut == p, "R3 second toggle", pinOut, p);
    for (int i = 0; i < 4; i++) drive(16'h0001, 1'b1);
    chk(matchFlag == 1'b1, "R10 flag sticky", matchFlag, 1);
    flagClr = 1'b1; cyc(); flagClr = 1'b0;
    chk(matchFlag == 1'b0, "R10 flag cleared", matchFlag, 0);
    flagClr = 1'b1; drive(16'h2050, 1'b1); flagClr = 1'b0;
    chk(matchFlag == 1'b1, "R10 set wins over clear", matchFlag, 1);
    flagClr = 1'b1; cyc(); flagClr = 1'b0;

    // R9 flag in high-speed mode, R7 in high-speed mode
    wrMode(4'b1101); wrLo(8'h00); wrHi(8'h80);
    drive(16'h8000, 1'b1);
    chk(matchFlag == 1'b1, "R9 hs full match flag", matchFlag, 1);
    wrLo(8'h77);
    p = pinOut;
    drive(16'h8077, 1'b1);
    chk(pinOut == p, "R7 disarmed no toggle", pinOut, p);
    wrHi(8'h80);
    drive(16'h8077, 1'b1);
    chk(pinOut == !p, "R7 rearmed toggles", pinOut, !p);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule